// File: doc/BRIEF.md
# Glitch-Free Clock Stop Gating

This block sits between the clock dividers of a clock synthesizer and its output buffers. It decides, for every output, whether that output runs or is held low. Two things control this decision. The first is a per-output enable bit from the serial control registers. The second is a pair of active-low stop pins: one stops the processor-side group and the other stops the PCI group. One output in each family is free-running: the stop pins never affect it, and only its own enable bit can stop it.

Every change between running and stopped is qualified in two steps. The block first waits for a rising edge of the free-running PCI clock. It then applies the change at the next falling edge of the output's own source clock. As a result, an output is always stopped low and never produces a shortened high pulse. A strap input can make the stop pins unusable, and a float control deasserts a shared output enable.

All source clocks are modelled as levels that are sampled by one fast reference clock. Each gated output is therefore a registered copy of its source, delayed by one reference cycle.

Top module: `clk_stop_gate`

## Requirements
- R1: A stopped output is held at 0. Every high pulse on an output lasts exactly as many reference cycles as the matching high phase of its source, so no pulse is ever cut short when the output stops or restarts.
- R2: A run/stop change takes effect only at a falling edge of the output's source. That falling edge must follow a rising edge of `pci_free_i` that occurs after the synchronized request. A request made just after a free PCI rising edge leaves the output running through that PCI period.
- R3: With `cpu_stop_ni` low and `mode_i` 0, the outputs `cpu_o`, `apic_o` and `sdram_o` stop. The outputs `cpu_free_o`, `apic_free_o`, `sdram_free_o` and all PCI outputs keep toggling.
- R4: With `pci_stop_ni` low and `mode_i` 0, `pci_o` stops while `pci_free_o` and every processor-side output keep toggling. Releasing the pin restarts `pci_o`.
- R5: An output toggles only while its own enable bit is 1 and the stop pin of its group is not asserted. Clearing an enable bit stops only the output that bit controls.
- R6: While the `mode_i` strap is 1, both stop pins are ignored and all enabled outputs toggle.
- R7: Suppose a stop pin changes one reference cycle after a rising edge of `pci_free_i`. Then the processor-side outputs stop, and also restart, within 4 CPU clock periods. The PCI outputs stop within 2 PCI clock periods.
- R8: `oe_o` is 0 while `float_i` is 1, and 1 otherwise.
- R9: While `rst_ni` is low, every clock output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock that samples all source clocks |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_clk_i | input | 1 | Internal CPU clock level (feeds the CPU and SDRAM outputs) |
| pci_clk_i | input | 1 | Internal PCI clock level |
| pci_free_i | input | 1 | Free-running PCI clock level; its rising edges qualify every change |
| ref_clk_i | input | 1 | Crystal reference level (feeds the APIC outputs) |
| cpu_stop_ni | input | 1 | Active-low stop for the processor-side group |
| pci_stop_ni | input | 1 | Active-low stop for the PCI group |
| mode_i | input | 1 | Strap; 1 disables both stop pins |
| float_i | input | 1 | 1 requests high impedance on all outputs |
| en_cpu_free_i | input | 1 | Enable for the free-running CPU output |
| en_cpu_i | input | CPU_N | Enables for the stoppable CPU outputs |
| en_apic_free_i | input | 1 | Enable for the free-running APIC output |
| en_apic_i | input | APIC_N | Enables for the stoppable APIC outputs |
| en_sdram_free_i | input | 1 | Enable for the free-running SDRAM output |
| en_sdram_i | input | SDRAM_N | Enables for the SDRAM output groups |
| en_pci_free_i | input | 1 | Enable for the free-running PCI output |
| en_pci_i | input | PCI_N | Enables for the stoppable PCI outputs |
| cpu_free_o | output | 1 | Free-running CPU clock |
| cpu_o | output | CPU_N | Stoppable CPU clocks |
| apic_free_o | output | 1 | Free-running APIC clock |
| apic_o | output | APIC_N | Stoppable APIC clocks |
| sdram_free_o | output | 1 | Free-running SDRAM clock |
| sdram_o | output | SDRAM_N | Stoppable SDRAM group clocks |
| pci_free_o | output | 1 | Gated copy of the free-running PCI clock |
| pci_o | output | PCI_N | Stoppable PCI clocks |
| oe_o | output | 1 | Shared output enable for the pad drivers |

## Verification
The assertions depend on two conditions holding. Each source clock must stay at each level for at least one reference cycle. The `mode_i` strap must be set only while reset is held, because it is treated as fixed after power-up. The bench meets both conditions. It derives every source from a single counter, with high and low phases of three, five or six cycles. It changes the strap only inside a reset pulse. It drives the stop pins one nanosecond after a reference edge, in step with a free PCI rising edge, as a synchronous chipset would.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

  // which stop pin, if any, governs an output
  typedef enum logic [1:0] {
    STOP_NONE = 2'd0,
    STOP_CPU  = 2'd1,
    STOP_PCI  = 2'd2
  } stop_grp_e;

  typedef struct packed {
    logic cpu;
    logic pci;
  } stop_req_t;

  function automatic logic stop_hits(input stop_grp_e grp, input stop_req_t req);
    case (grp)
      STOP_CPU: return req.cpu;
      STOP_PCI: return req.pci;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/clk_stop_sync.sv
module clk_stop_sync
  import clk_stop_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cpu_stop_ni,
  input  logic      pci_stop_ni,
  input  logic      mode_i,
  input  logic      pci_free_i,
  output stop_req_t stop_o,
  output logic      pci_rise_o
);

  localparam int NPIN = 2;

  logic [NPIN-1:0]              pin_n;
  logic [STAGES-1:0][NPIN-1:0]  sync_q;
  logic [NPIN-1:0]              pin_sync_n;
  stop_req_t                    stop_q;
  logic                         pci_free_q;

  assign pin_n      = {pci_stop_ni, cpu_stop_ni};
  assign pin_sync_n = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q     <= '1;
      stop_q     <= '0;
      pci_free_q <= 1'b0;
    end else begin
      sync_q     <= {sync_q[STAGES-2:0], pin_n};
      stop_q.cpu <= ~pin_sync_n[0] & ~mode_i;
      stop_q.pci <= ~pin_sync_n[1] & ~mode_i;
      pci_free_q <= pci_free_i;
    end
  end

  assign stop_o     = stop_q;
  assign pci_rise_o = pci_free_i & ~pci_free_q;

  // strap set keeps both stop requests clear
  assert_mode_masks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_i) |-> (!stop_q.cpu && !stop_q.pci));

endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell
  import clk_stop_pkg::*;
#(
  parameter stop_grp_e GRP = STOP_NONE
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      src_i,
  input  logic      pci_rise_i,
  input  stop_req_t stop_i,
  input  logic      en_i,
  output logic      clk_o
);

  logic want, pend, src_fall;
  logic src_q, run_q, armed_q, out_q;

  assign want     = en_i & ~stop_hits(GRP, stop_i);
  assign pend     = want ^ run_q;
  assign src_fall = src_q & ~src_i;

  // run state moves only while the source is low: pulses stay whole
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= 1'b0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      src_q <= src_i;
      out_q <= src_i & run_q;
      if (!pend) begin
        armed_q <= 1'b0;
      end else if (armed_q && src_fall) begin
        run_q   <= want;
        armed_q <= 1'b0;
      end else if (pci_rise_i) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign clk_o = out_q;

  assert_fall_full_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_o) |-> !$past(src_i));

  assert_rise_full_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_o) |-> ($past(src_i) && !$past(src_i, 2)));

  assert_run_qualified_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q != $past(run_q)) |-> ($past(armed_q) && !$past(src_i)));

endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank
  import clk_stop_pkg::*;
#(
  parameter int        N   = 1,
  parameter stop_grp_e GRP = STOP_NONE
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         src_i,
  input  logic         pci_rise_i,
  input  stop_req_t    stop_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] clk_o
);

  for (genvar i = 0; i < N; i++) begin : g_cell
    clk_gate_cell #(.GRP(GRP)) i_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_i),
      .pci_rise_i (pci_rise_i),
      .stop_i     (stop_i),
      .en_i       (en_i[i]),
      .clk_o      (clk_o[i])
    );
  end

endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import clk_stop_pkg::*;
#(
  parameter int CPU_N       = 2,
  parameter int APIC_N      = 1,
  parameter int SDRAM_N     = 4,
  parameter int PCI_N       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cpu_clk_i,
  input  logic               pci_clk_i,
  input  logic               pci_free_i,
  input  logic               ref_clk_i,
  input  logic               cpu_stop_ni,
  input  logic               pci_stop_ni,
  input  logic               mode_i,
  input  logic               float_i,
  input  logic               en_cpu_free_i,
  input  logic [CPU_N-1:0]   en_cpu_i,
  input  logic               en_apic_free_i,
  input  logic [APIC_N-1:0]  en_apic_i,
  input  logic               en_sdram_free_i,
  input  logic [SDRAM_N-1:0] en_sdram_i,
  input  logic               en_pci_free_i,
  input  logic [PCI_N-1:0]   en_pci_i,
  output logic               cpu_free_o,
  output logic [CPU_N-1:0]   cpu_o,
  output logic               apic_free_o,
  output logic [APIC_N-1:0]  apic_o,
  output logic               sdram_free_o,
  output logic [SDRAM_N-1:0] sdram_o,
  output logic               pci_free_o,
  output logic [PCI_N-1:0]   pci_o,
  output logic               oe_o
);

  stop_req_t stop_req;
  logic      pci_rise;

  clk_stop_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_stop_ni (cpu_stop_ni),
    .pci_stop_ni (pci_stop_ni),
    .mode_i      (mode_i),
    .pci_free_i  (pci_free_i),
    .stop_o      (stop_req),
    .pci_rise_o  (pci_rise)
  );

  clk_gate_bank #(.N(1), .GRP(STOP_NONE)) i_cpu_free (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(cpu_clk_i), .pci_rise_i(pci_rise),
    .stop_i(stop_req), .en_i(en_cpu_free_i), .clk_o(cpu_free_o));

  clk_gate_bank #(.N(CPU_N), .GRP(STOP_CPU)) i_cpu (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(cpu_clk_i), .pci_rise_i(pci_rise),
    .stop_i(stop_req), .en_i(en_cpu_i), .clk_o(cpu_o));

  clk_gate_bank #(.N(1), .GRP(STOP_NONE)) i_apic_free (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(ref_clk_i), .pci_rise_i(pci_rise),
    .stop_i(stop_req), .en_i(en_apic_free_i), .clk_o(apic_free_o));

  clk_gate_bank #(.N(APIC_N), .GRP(STOP_CPU)) i_apic (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(ref_clk_i), .pci_rise_i(pci_rise),
    .stop_i(stop_req), .en_i(en_apic_i), .clk_o(apic_o));

  clk_gate_bank #(.N(1), .GRP(STOP_NONE)) i_sdram_free (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(cpu_clk_i), .pci_rise_i(pci_rise),
    .stop_i(stop_req), .en_i(en_sdram_free_i), .clk_o(sdram_free_o));

  clk_gate_bank #(.N(SDRAM_N), .GRP(STOP_CPU)) i_sdram (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(cpu_clk_i), .pci_rise_i(pci_rise),
    .stop_i(stop_req), .en_i(en_sdram_i), .clk_o(sdram_o));

  clk_gate_bank #(.N(1), .GRP(STOP_NONE)) i_pci_free (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(pci_free_i), .pci_rise_i(pci_rise),
    .stop_i(stop_req), .en_i(en_pci_free_i), .clk_o(pci_free_o));

  clk_gate_bank #(.N(PCI_N), .GRP(STOP_PCI)) i_pci (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(pci_clk_i), .pci_rise_i(pci_rise),
    .stop_i(stop_req), .en_i(en_pci_i), .clk_o(pci_o));

  assign oe_o = ~float_i;

endmodule

// File: tb/test_clk_stop_gate.sv
module test_clk_stop_gate;

  localparam int NO = 17;
  // bit map of outs: 0 cpu_free, 2:1 cpu, 3 apic_free, 4 apic, 5 sdram_free,
  // 9:6 sdram, 10 pci_free, 16:11 pci
  localparam logic [NO-1:0] ALL  = 17'h1FFFF;
  localparam logic [NO-1:0] CGRP = 17'h003D6;
  localparam logic [NO-1:0] PGRP = 17'h1F800;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  int   cnt = 0;
  logic cpu_src, pci_src, ref_src;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, mode = 1'b0, flt = 1'b0;
  logic en_cpu_free = 1'b1, en_apic_free = 1'b1, en_sdram_free = 1'b1, en_pci_free = 1'b1;
  logic [1:0] en_cpu = '1;
  logic [0:0] en_apic = '1;
  logic [3:0] en_sdram = '1;
  logic [5:0] en_pci = '1;
  logic cpu_free, apic_free, sdram_free, pci_free, oe;
  logic [1:0] cpu;
  logic [0:0] apic;
  logic [3:0] sdram;
  logic [5:0] pci;
  logic [NO-1:0] outs;
  int n_chk = 0, n_fail = 0, cycles = 0;
  int run_len [NO];

  always #4 clk = ~clk;
  always @(negedge clk) cnt <= cnt + 1;

  assign cpu_src = (cnt % 6) < 3;
  assign pci_src = (cnt % 12) < 6;
  assign ref_src = (cnt % 10) < 5;
  assign outs = {pci, pci_free, sdram, sdram_free, apic, apic_free, cpu, cpu_free};

  clk_stop_gate i_clk_stop_gate (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_clk_i(cpu_src), .pci_clk_i(pci_src),
    .pci_free_i(pci_src), .ref_clk_i(ref_src), .cpu_stop_ni(cpu_stop_n),
    .pci_stop_ni(pci_stop_n), .mode_i(mode), .float_i(flt),
    .en_cpu_free_i(en_cpu_free), .en_cpu_i(en_cpu), .en_apic_free_i(en_apic_free),
    .en_apic_i(en_apic), .en_sdram_free_i(en_sdram_free), .en_sdram_i(en_sdram),
    .en_pci_free_i(en_pci_free), .en_pci_i(en_pci),
    .cpu_free_o(cpu_free), .cpu_o(cpu), .apic_free_o(apic_free), .apic_o(apic),
    .sdram_free_o(sdram_free), .sdram_o(sdram), .pci_free_o(pci_free), .pci_o(pci),
    .oe_o(oe));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int half_of(input int b);
    if (b == 3 || b == 4) return 5;
    if (b >= 10) return 6;
    return 3;
  endfunction

  // R1: every high pulse as long as its source high phase
  always @(negedge clk) begin
    if (!rst_ni) begin
      for (int b = 0; b < NO; b++) run_len[b] = 0;
    end else begin
      for (int b = 0; b < NO; b++) begin
        if (outs[b]) run_len[b]++;
        else begin
          if (run_len[b] != 0) check(run_len[b] == half_of(b), "R1 pulse width", run_len[b], half_of(b));
          run_len[b] = 0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <= 20000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic observe(input int n, output logic [NO-1:0] hi);
    hi = '0;
    repeat (n) begin
      @(negedge clk);
      hi |= outs;
    end
  endtask

  task automatic align_pci();
    do @(posedge clk); while (cnt % 12 != 0);
    #1;
  endtask

  task automatic do_reset(input logic m);
    logic [NO-1:0] hi;
    rst_ni = 1'b0;
    mode = m;
    observe(6, hi);
    check(hi == '0, "R9 outputs low in reset", 32'(hi), 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    repeat (40) @(posedge clk);
  endtask

  task automatic t_all_run();
    logic [NO-1:0] hi;
    observe(36, hi);
    check(hi == ALL, "R5 all enabled outputs toggle", 32'(hi), 32'(ALL));
    check(oe == 1'b1, "R8 oe with float clear", 32'(oe), 1);
  endtask

  task automatic t_cpu_stop();
    logic [NO-1:0] hi;
    align_pci();
    cpu_stop_n = 1'b0;
    repeat (11) @(posedge clk);
    observe(4, hi);
    check(hi[2:1] == 2'b11, "R2 stop waits for next free PCI rise", 32'(hi[2:1]), 3);
    repeat (9) @(posedge clk);
    observe(12, hi);
    check((hi & CGRP) == '0, "R7 cpu group stopped within 4 CPU periods", 32'(hi & CGRP), 0);
    observe(36, hi);
    check(hi == (ALL & ~CGRP), "R3 cpu stop affects only its group", 32'(hi), 32'(ALL & ~CGRP));
    align_pci();
    cpu_stop_n = 1'b1;
    observe(24, hi);
    check(hi[2:1] == 2'b11, "R7 cpu restart within 4 CPU periods", 32'(hi[2:1]), 3);
    repeat (12) @(posedge clk);
    observe(36, hi);
    check(hi == ALL, "R3 cpu group resumes", 32'(hi), 32'(ALL));
  endtask

  task automatic t_pci_stop();
    logic [NO-1:0] hi;
    align_pci();
    pci_stop_n = 1'b0;
    repeat (24) @(posedge clk);
    observe(12, hi);
    check((hi & PGRP) == '0, "R7 pci stopped within 2 PCI periods", 32'(hi & PGRP), 0);
    observe(36, hi);
    check(hi == (ALL & ~PGRP), "R4 pci stop keeps free PCI running", 32'(hi), 32'(ALL & ~PGRP));
    align_pci();
    pci_stop_n = 1'b1;
    observe(30, hi);
    check((hi & PGRP) == PGRP, "R4 pci restart", 32'(hi & PGRP), 32'(PGRP));
  endtask

  task automatic t_both_stop();
    logic [NO-1:0] hi;
    align_pci();
    cpu_stop_n = 1'b0;
    pci_stop_n = 1'b0;
    repeat (40) @(posedge clk);
    observe(36, hi);
    check(hi == (ALL & ~CGRP & ~PGRP), "R3 R4 both pins low", 32'(hi), 32'(ALL & ~CGRP & ~PGRP));
    cpu_stop_n = 1'b1;
    pci_stop_n = 1'b1;
    repeat (40) @(posedge clk);
    observe(36, hi);
    check(hi == ALL, "R3 R4 both released", 32'(hi), 32'(ALL));
  endtask

  task automatic t_enable();
    logic [NO-1:0] hi;
    logic [NO-1:0] exp;
    en_cpu_free = 1'b0;
    en_sdram[1] = 1'b0;
    en_pci[2]   = 1'b0;
    exp = ALL & ~17'h00001 & ~17'h00080 & ~17'h02000;
    repeat (40) @(posedge clk);
    observe(36, hi);
    check(hi == exp, "R5 cleared enables stop only their outputs", 32'(hi), 32'(exp));
    en_cpu_free = 1'b1;
    en_sdram[1] = 1'b1;
    en_pci[2]   = 1'b1;
    repeat (40) @(posedge clk);
    observe(36, hi);
    check(hi == ALL, "R5 re-enabled outputs toggle", 32'(hi), 32'(ALL));
  endtask

  task automatic t_float();
    @(posedge clk); #1 flt = 1'b1;
    @(negedge clk);
    check(oe == 1'b0, "R8 float deasserts oe", 32'(oe), 0);
    @(posedge clk); #1 flt = 1'b0;
    @(negedge clk);
    check(oe == 1'b1, "R8 float cleared", 32'(oe), 1);
  endtask

  task automatic t_mode();
    logic [NO-1:0] hi;
    do_reset(1'b1);
    cpu_stop_n = 1'b0;
    pci_stop_n = 1'b0;
    repeat (40) @(posedge clk);
    observe(36, hi);
    check(hi == ALL, "R6 strap ignores stop pins", 32'(hi), 32'(ALL));
    cpu_stop_n = 1'b1;
    pci_stop_n = 1'b1;
    do_reset(1'b0);
  endtask

  initial begin
    do_reset(1'b0);
    t_all_run();
    t_cpu_stop();
    t_pci_stop();
    t_both_stop();
    t_enable();
    t_float();
    t_mode();
    t_all_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule